// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a parallel NOR-style flash with an 8-bit data lane. It takes one request at a time: program one byte, erase one sector, or erase the whole array. For each request it produces the unlock and command write cycles the flash expects. It then reads the status byte repeatedly until bit 7 shows that the operation inside the flash has finished. At the end it raises either a completion pulse or an error pulse.

Every bus strobe width is derived from nanosecond parameters and the clock period, rounding up to whole cycles. The sequencer drives only the flash select. The select of the SRAM that shares the bus is held inactive at all times.

The request side uses a valid/ready handshake and a single busy flag. Timeout limits, counted in clock cycles, are set separately for each operation type. Once a timeout error is reported the sequencer is back in idle and accepts new work.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, flash_cs_n, flash_we_n, flash_oe_n and sram_cs_n are 1, flash_dq_oe is 0, busy, done and error are 0, and req_ready is 1.
- R2: A request with req_op = 0 (byte program) produces exactly four write cycles, as (address, data) pairs in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), (req_addr, req_data).
- R3: A request with req_op = 1 (sector erase) produces exactly six write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (req_addr, 0x30).
- R4: A request with req_op = 2 (full erase) produces the same first five write cycles as R3, and the sixth is (0x5555, 0x10).
- R5: On every write cycle, flash_we_n stays low for exactly max(ceil(WE_LOW_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS)) cycles, which is 9 at the defaults. Between two low pulses it stays high for at least ceil(WE_HIGH_NS/CLK_NS) cycles, which is 5. flash_cs_n is low while flash_we_n is low. flash_addr and flash_dq_out do not change while flash_we_n is low.
- R6: sram_cs_n is 1 whenever flash_cs_n is 0. flash_we_n and flash_oe_n are never low together. flash_dq_oe is 0 whenever flash_oe_n is low.
- R7: After the final write, the block performs read cycles with flash_oe_n low. The operation completes on the first read in which bit 7 equals the expected value: bit 7 of req_data for a program, 1 for either erase. A read whose bit 7 differs from the expected value starts another read. Exactly one read follows the last differing one.
- R8: The per-type timer starts after the final write. If a read ends without a match and the timer has reached the limit for that operation type (PROG/SECT/CHIP_TIMEOUT_CYC), error pulses instead of done and the block returns to idle.
- R9: req_ready equals the inverse of busy. busy rises on the cycle after a request is accepted. A request presented while busy is ignored: it causes no bus cycles, either during the current operation or after it.
- R10: done and error are single-cycle pulses and are never high together. busy falls in the same cycle that one of them is raised, and only then.
- R11: A request with req_op = 3 is dropped. busy stays low and no bus cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_op | input | 2 | 0 program, 1 sector erase, 2 full erase, 3 reserved |
| req_addr | input | ADDR_W | Byte address to program, or an address inside the sector to erase |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| error | output | 1 | One-cycle pulse: completion not seen within the limit |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | 8 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | 8 | Data read from the flash |
| flash_cs_n | output | 1 | Flash select, active low |
| flash_we_n | output | 1 | Flash write strobe, active low |
| flash_oe_n | output | 1 | Flash read strobe, active low |
| sram_cs_n | output | 1 | Select of the SRAM sharing the bus, held inactive |

## Verification
The hardest situation to reach from the ports is the timeout: it only occurs when the flash never reports completion, however long the block keeps polling. The bench's flash model answers each read with the complement of the true bit 7 for a programmable number of reads, and that number can be made effectively unbounded. The timeout limits are overridden to a few hundred cycles so the error path runs within a short test. The same knob, set to small random values, exercises completion on the first read and after several differing reads. For programs, the data byte's bit 7 is forced both high and low.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } fseq_op_e;

  localparam logic [15:0] UNLOCK_HI = 16'h5555;
  localparam logic [15:0] UNLOCK_LO = 16'h2AAA;

  function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fseq_cmd_table.sv
module fseq_cmd_table
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned STEP_W = 3
) (
  input  fseq_op_e              op,
  input  logic [STEP_W-1:0]     step,
  input  logic [ADDR_W-1:0]     tgt_addr,
  input  logic [7:0]            tgt_data,
  output logic [ADDR_W-1:0]     cyc_addr,
  output logic [7:0]            cyc_data,
  output logic                  last
);

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_LO);

  always_comb begin
    cyc_addr = A_HI;
    cyc_data = 8'hAA;
    last     = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        STEP_W'(0): begin cyc_addr = A_HI; cyc_data = 8'hAA; end
        STEP_W'(1): begin cyc_addr = A_LO; cyc_data = 8'h55; end
        STEP_W'(2): begin cyc_addr = A_HI; cyc_data = 8'hA0; end
        default: begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
          last     = 1'b1;
        end
      endcase
    end else begin
      case (step)
        STEP_W'(0): begin cyc_addr = A_HI; cyc_data = 8'hAA; end
        STEP_W'(1): begin cyc_addr = A_LO; cyc_data = 8'h55; end
        STEP_W'(2): begin cyc_addr = A_HI; cyc_data = 8'h80; end
        STEP_W'(3): begin cyc_addr = A_HI; cyc_data = 8'hAA; end
        STEP_W'(4): begin cyc_addr = A_LO; cyc_data = 8'h55; end
        default: begin
          last = 1'b1;
          if (op == OP_SECT) begin
            cyc_addr = tgt_addr;
            cyc_data = 8'h30;
          end else begin
            cyc_addr = A_HI;
            cyc_data = 8'h10;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fseq_bus_cycle.sv
module fseq_bus_cycle
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WR_LO  = 9,
  parameter int unsigned WR_HI  = 5,
  parameter int unsigned RD_LO  = 18,
  parameter int unsigned RD_HI  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        dq_in,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [7:0]        rd_data,
  output logic              cyc_done
);

  localparam int unsigned CMAX  = max2(max2(WR_LO, WR_HI), max2(RD_LO, RD_HI));
  localparam int unsigned CNT_W = $clog2(CMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} ph_e;

  ph_e              ph;
  logic             rd_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      addr_o   <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_q     <= 1'b0;
      cnt      <= '0;
      rd_data  <= '0;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph     <= PH_SETUP;
            cs_n   <= 1'b0;
            addr_o <= addr_i;
            dq_out <= data_i;
            dq_oe  <= ~is_read;
            rd_q   <= is_read;
          end
        end
        PH_SETUP: begin
          ph <= PH_STROBE;
          if (rd_q) begin
            oe_n <= 1'b0;
            cnt  <= CNT_W'(RD_LO - 1);
          end else begin
            we_n <= 1'b0;
            cnt  <= CNT_W'(WR_LO - 1);
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            oe_n <= 1'b1;
            ph   <= PH_RECOV;
            if (rd_q) begin
              rd_data <= dq_in;
              cnt     <= CNT_W'(RD_HI - 1);
            end else begin
              cnt     <= CNT_W'(WR_HI - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            cs_n     <= 1'b1;
            dq_oe    <= 1'b0;
            cyc_done <= 1'b1;
            ph       <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int unsigned TMR_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);

  logic [TMR_W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned CLK_NS        = 4,
  parameter int unsigned WE_LOW_NS     = 35,
  parameter int unsigned WE_HIGH_NS    = 20,
  parameter int unsigned ADDR_HOLD_NS  = 45,
  parameter int unsigned DATA_SETUP_NS = 30,
  parameter int unsigned RD_ACCESS_NS  = 70,
  parameter int unsigned RD_RELEASE_NS = 20,
  parameter int unsigned TMR_W         = 36,
  parameter logic [TMR_W-1:0] PROG_TIMEOUT_CYC = 36'd100_000,
  parameter logic [TMR_W-1:0] SECT_TIMEOUT_CYC = 36'd3_750_000_000,
  parameter logic [TMR_W-1:0] CHIP_TIMEOUT_CYC = 36'd17_500_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in,
  output logic              flash_cs_n,
  output logic              flash_we_n,
  output logic              flash_oe_n,
  output logic              sram_cs_n
);

  localparam int unsigned STEP_W  = 3;
  localparam int unsigned WR_LO   = max2(max2(cyc_ceil(WE_LOW_NS, CLK_NS),
                                              cyc_ceil(DATA_SETUP_NS, CLK_NS)), 1);
  localparam int unsigned HI_BASE = max2(cyc_ceil(WE_HIGH_NS, CLK_NS), 1);
  localparam int unsigned HOLD_C  = cyc_ceil(ADDR_HOLD_NS, CLK_NS);
  localparam int unsigned WR_HI   = (WR_LO + HI_BASE >= HOLD_C) ? HI_BASE : (HOLD_C - WR_LO);
  localparam int unsigned RD_LO   = max2(cyc_ceil(RD_ACCESS_NS, CLK_NS), 1);
  localparam int unsigned RD_HI   = max2(cyc_ceil(RD_RELEASE_NS, CLK_NS), 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_POLL} st_e;

  st_e               state;
  fseq_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [STEP_W-1:0] step_q;
  logic              bus_start;
  logic              busy_q;
  logic              done_q;
  logic              error_q;
  logic              tmr_clear;

  logic [ADDR_W-1:0] cyc_addr;
  logic [7:0]        cyc_data;
  logic              cyc_last;
  logic              bus_done;
  logic [7:0]        rd_data;
  logic              tmr_exp;
  logic [TMR_W-1:0]  tmr_limit;
  logic              want7;

  assign req_ready = ~busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign error     = error_q;
  assign sram_cs_n = 1'b1;
  assign want7     = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  always_comb begin
    case (op_q)
      OP_PROG: tmr_limit = PROG_TIMEOUT_CYC;
      OP_SECT: tmr_limit = SECT_TIMEOUT_CYC;
      default: tmr_limit = CHIP_TIMEOUT_CYC;
    endcase
  end

  fseq_cmd_table #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_table (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .last     (cyc_last)
  );

  fseq_bus_cycle #(
    .ADDR_W (ADDR_W),
    .WR_LO  (WR_LO),
    .WR_HI  (WR_HI),
    .RD_LO  (RD_LO),
    .RD_HI  (RD_HI)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .start    (bus_start),
    .is_read  (state == ST_POLL),
    .addr_i   (cyc_addr),
    .data_i   (cyc_data),
    .dq_in    (flash_dq_in),
    .cs_n     (flash_cs_n),
    .we_n     (flash_we_n),
    .oe_n     (flash_oe_n),
    .addr_o   (flash_addr),
    .dq_out   (flash_dq_out),
    .dq_oe    (flash_dq_oe),
    .rd_data  (rd_data),
    .cyc_done (bus_done)
  );

  fseq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (state == ST_POLL),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      step_q    <= '0;
      bus_start <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
      tmr_clear <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
      tmr_clear <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && (fseq_op_e'(req_op) != OP_RSVD)) begin
            op_q      <= fseq_op_e'(req_op);
            addr_q    <= req_addr;
            data_q    <= req_data;
            step_q    <= '0;
            busy_q    <= 1'b1;
            bus_start <= 1'b1;
            state     <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (bus_done) begin
            bus_start <= 1'b1;
            if (cyc_last) begin
              state     <= ST_POLL;
              tmr_clear <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: begin
          if (bus_done) begin
            if (rd_data[7] == want7) begin
              done_q <= 1'b1;
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else if (tmr_exp) begin
              error_q <= 1'b1;
              busy_q  <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              bus_start <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fseq_sva.sv
module fseq_sva #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WR_LO  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              sram_cs_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out
);

  localparam int unsigned LW = $clog2(WR_LO + 2);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || we_n) lo_cnt <= '0;
    else if (lo_cnt != {LW{1'b1}}) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(we_n) |-> lo_cnt == LW'(WR_LO)); // R5
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) !we_n |-> !cs_n); // R5
  AST_WR_BUS_STABLE: assert property (@(posedge clk) disable iff (rst) (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out))); // R5
  AST_SRAM_DESEL: assert property (@(posedge clk) disable iff (rst) !cs_n |-> sram_cs_n); // R6
  AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (rst) !(!we_n && !oe_n)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst) !oe_n |-> !dq_oe); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && error)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (done || error)); // R10
  AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) (done || error) |-> !busy); // R10

endmodule

bind flash_cmd_seq fseq_sva #(.ADDR_W(ADDR_W), .WR_LO(WR_LO)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .cs_n      (flash_cs_n),
  .we_n      (flash_we_n),
  .oe_n      (flash_oe_n),
  .dq_oe     (flash_dq_oe),
  .sram_cs_n (sram_cs_n),
  .addr      (flash_addr),
  .dq_out    (flash_dq_out)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int AW       = 17;
  localparam int T_NS     = 4;
  localparam int EXP_LO   = ((35 + T_NS - 1) / T_NS > (30 + T_NS - 1) / T_NS) ? (35 + T_NS - 1) / T_NS : (30 + T_NS - 1) / T_NS;
  localparam int EXP_HI   = (20 + T_NS - 1) / T_NS;
  localparam int LIM_PROG = 600;
  localparam int LIM_SECT = 900;
  localparam int LIM_CHIP = 1200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          busy, done, error;
  logic [AW-1:0] flash_addr;
  logic [7:0]    flash_dq_out, flash_dq_in;
  logic          flash_dq_oe, flash_cs_n, flash_we_n, flash_oe_n, sram_cs_n;

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W           (AW),
    .CLK_NS           (T_NS),
    .PROG_TIMEOUT_CYC (36'(LIM_PROG)),
    .SECT_TIMEOUT_CYC (36'(LIM_SECT)),
    .CHIP_TIMEOUT_CYC (36'(LIM_CHIP))
  ) u_dut (
    .clk, .rst, .req_valid, .req_ready, .req_op, .req_addr, .req_data,
    .busy, .done, .error, .flash_addr, .flash_dq_out, .flash_dq_oe,
    .flash_dq_in, .flash_cs_n, .flash_we_n, .flash_oe_n, .sram_cs_n
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // flash model
  logic [AW-1:0] log_addr [0:15];
  logic [7:0]    log_data [0:15];
  int            wr_cnt = 0;
  int            rd_cnt = 0;
  int            m_left = 0;
  logic [7:0]    m_true = 8'hFF;
  logic          m_busy = 1'b0;

  assign flash_dq_in = m_busy ? {~m_true[7], 7'h2A} : m_true;

  always @(posedge flash_we_n) begin
    if (!rst && !flash_cs_n) begin
      if (wr_cnt < 16) begin
        log_addr[wr_cnt] = flash_addr;
        log_data[wr_cnt] = flash_dq_out;
      end
      wr_cnt++;
    end
  end

  always @(negedge flash_oe_n) begin
    if (!rst && !flash_cs_n) begin
      rd_cnt++;
      if (m_left > 0) begin
        m_busy = 1'b1;
        m_left--;
      end else begin
        m_busy = 1'b0;
      end
    end
  end

  // strobe monitors
  int lo = 0, hi = 1000;
  int viol_lo = 0, viol_hi = 0, viol_stab = 0, viol_bus = 0, pulses = 0;
  logic [AW-1:0] fall_addr;
  logic [7:0]    fall_data;

  always @(negedge clk) begin
    if (!rst) begin
      if (!flash_cs_n && !sram_cs_n) viol_bus++;
      if (!flash_we_n && !flash_oe_n) viol_bus++;
      if (!flash_oe_n && flash_dq_oe) viol_bus++;
      if (!flash_we_n) begin
        if (lo == 0) begin
          if (hi < EXP_HI) viol_hi++;
          fall_addr = flash_addr;
          fall_data = flash_dq_out;
        end else if (flash_addr != fall_addr || flash_dq_out != fall_data || flash_cs_n) begin
          viol_stab++;
        end
        lo++;
        hi = 0;
      end else begin
        if (lo != 0) begin
          pulses++;
          if (lo != EXP_LO) viol_lo++;
        end
        lo = 0;
        hi++;
      end
    end
  end

  function automatic logic [AW-1:0] e_addr(input int op, input logic [AW-1:0] a, input int i);
    if (op == 0) begin
      if (i == 0 || i == 2) return 17'h05555;
      if (i == 1) return 17'h02AAA;
      return a;
    end
    if (i == 0 || i == 2 || i == 3) return 17'h05555;
    if (i == 1 || i == 4) return 17'h02AAA;
    return (op == 1) ? a : 17'h05555;
  endfunction

  function automatic logic [7:0] e_data(input int op, input logic [7:0] d, input int i);
    if (op == 0) begin
      case (i)
        0: return 8'hAA;
        1: return 8'h55;
        2: return 8'hA0;
        default: return d;
      endcase
    end
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return (op == 1) ? 8'h30 : 8'h10;
    endcase
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int polls, input bit expect_to);
    int cyc;
    int nwr;
    int bad;
    int lim;
    string tag;
    tag = (op == 0) ? "R2" : ((op == 1) ? "R3" : "R4");
    nwr = (op == 0) ? 4 : 6;
    lim = (op == 0) ? LIM_PROG : ((op == 1) ? LIM_SECT : LIM_CHIP);
    wr_cnt = 0;
    rd_cnt = 0;
    m_left = polls;
    m_busy = 1'b0;
    m_true = (op == 0) ? d : 8'hFF;
    @(negedge clk);
    check(req_ready == 1'b1 && busy == 1'b0, "R9 ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_addr  = a;
    req_data  = d;
    @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R9 busy after accept", busy, 1);
    // conflicting request while busy must be ignored
    req_op   = (op == 0) ? 2'd2 : 2'd0;
    req_addr = ~a;
    req_data = ~d;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    cyc = 6;
    while (!done && !error && cyc < lim + 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (expect_to) begin
      check(error == 1'b1 && done == 1'b0, "R8 timeout error", {done, error}, 2'b01);
      check(cyc >= lim && cyc <= lim + 400, "R8 timeout window", cyc, lim);
    end else begin
      check(done == 1'b1 && error == 1'b0, "R7 completion", {done, error}, 2'b10);
      check(rd_cnt == polls + 1, "R7 poll count", rd_cnt, polls + 1);
    end
    check(busy == 1'b0 && req_ready == 1'b1, "R10 busy clears with result", busy, 0);
    check(wr_cnt == nwr, {tag, " write count"}, wr_cnt, nwr);
    bad = 0;
    for (int i = 0; i < nwr && i < 16; i++) begin
      if (log_addr[i] != e_addr(op, a, i) || log_data[i] != e_data(op, d, i)) begin
        if (bad == 0)
          $display("FAIL %s: cycle %0d actual %0h/%0h expected %0h/%0h", tag, i,
                   log_addr[i], log_data[i], e_addr(op, a, i), e_data(op, d, i));
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
    @(negedge clk);
    check(done == 1'b0 && error == 1'b0, "R10 single-cycle result", {done, error}, 0);
    repeat (20) @(negedge clk);
    check(wr_cnt == nwr && busy == 1'b0, "R9 busy-time request ignored", wr_cnt, nwr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed_v;
    seed_v = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    check(flash_cs_n && flash_we_n && flash_oe_n && sram_cs_n && !flash_dq_oe,
          "R1 strobes in reset", {flash_cs_n, flash_we_n, flash_oe_n, sram_cs_n, flash_dq_oe}, 5'b11110);
    check(!busy && !done && !error && req_ready, "R1 status in reset", {busy, done, error, req_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    check(flash_cs_n && flash_we_n && flash_oe_n && !busy && req_ready, "R1 after reset",
          {flash_cs_n, flash_we_n, flash_oe_n, busy}, 4'b1110);

    // directed corners
    run_op(0, 17'h1ABCD, 8'h80, 0, 1'b0);   // R2 R7 bit 7 high, immediate
    run_op(0, 17'h00001, 8'h7F, 2, 1'b0);   // R2 R7 bit 7 low
    run_op(1, 17'h1C000, 8'h00, 3, 1'b0);   // R3
    run_op(2, 17'h00000, 8'h00, 1, 1'b0);   // R4

    // R11 reserved op dropped
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 17'h12345; req_data = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(busy == 1'b0 && wr_cnt == 0 && flash_cs_n, "R11 reserved op", wr_cnt, 0);

    // random mix
    for (int k = 0; k < 16; k++) begin
      int op;
      op = (k % 5 == 4) ? int'($urandom_range(2, 1)) : 0;
      run_op(op, AW'($urandom), 8'($urandom), int'($urandom_range(4, 0)), 1'b0);
    end

    // timeouts, then recovery
    run_op(0, 17'h0F0F0, 8'h3C, 1000000, 1'b1);  // R8
    run_op(1, 17'h04000, 8'h00, 1000000, 1'b1);  // R8
    run_op(0, 17'h0F0F0, 8'hC3, 1, 1'b0);        // R8 back to idle and usable

    check(viol_lo == 0 && pulses > 0, "R5 write low width", viol_lo, 0);
    check(viol_hi == 0, "R5 write high gap", viol_hi, 0);
    check(viol_stab == 0, "R5 bus stable while strobe low", viol_stab, 0);
    check(viol_bus == 0, "R6 select and drive exclusivity", viol_bus, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule